// File: doc/BRIEF.md
# Stepwise I2C Bus Master

A single-master I2C controller that advances the bus by exactly one protocol step (a START, a repeated START, one byte plus its acknowledge bit, or a STOP) and then freezes. Each completed step posts an 8-bit status code and sets an interrupt flag. The controller holds SCL low until software writes the flag back to zero. Software decides every next move from the status code: load the data register, request START or STOP, or choose whether a received byte is acknowledged.

Software reaches the block through a small synchronous register port. SCL and SDA are open-drain: an output enable of 1 pulls the line low, and the sampled line levels come back on two inputs. A one-cycle `tick` input sets the bit rate. Every bit takes four ticks: SCL low while SDA settles, SCL released, SDA sampled, SCL pulled low again.

Register offsets:
- 0x00: own address, storage only.
- 0x04: extended address, storage only.
- 0x08: data.
- 0x0C: control.
- 0x10: status, read-only.
- 0x14: clock setting, storage only.
- 0x18: soft reset. It always reads 0.

Control bits:
- bit 7: interrupt enable.
- bit 6: bus enable.
- bit 5: START request.
- bit 4: STOP request.
- bit 3: interrupt flag.
- bit 2: acknowledge received bytes.

Top module: `i2c_step_master`

## Requirements
- R1: After reset, status reads 0xF8, control reads 0x00, both drive enables are 0 and `irq` is 0.
- R2: A START request (control bit 5) made with bus enable set produces SDA falling while SCL is high, clears bit 5, sets the flag (bit 3) and posts 0x08. When made from a frozen step mid-transfer, it posts 0x10.
- R3: While the flag is 1, SCL is held low and the bus does not move. Writing bit 3 as 0 lets the next step run; writing it as 1 never sets it.
- R4: The first byte after any START is the data register (7-bit target in bits 7..1, read when bit 0 is 1), sent MSB first. The step posts 0x18 or 0x20 (write, acknowledged or not), or 0x40 or 0x48 (read, acknowledged or not).
- R5: Each later byte of a write transfer is taken from the data register and posts 0x28 when acknowledged and 0x30 when not.
- R6: In a read transfer, each byte is shifted in MSB first into the data register. The master drives ACK after it if control bit 2 was set, posting 0x50, and NACK otherwise, posting 0x58.
- R7: A STOP request (bit 4) from a frozen step produces SDA rising while SCL is high, then returns to idle with bit 4 cleared, the flag left at 0 and both lines released.
- R8: `irq` is 1 exactly when the flag and interrupt enable (bit 7) are both 1.
- R9: With bus enable (bit 6) at 0, a START request is ignored and both lines stay released.
- R10: An SDA change while SCL is high during a byte posts 0x00, sets the flag and releases both lines. Clearing the flag returns to idle, from which a new START works.
- R11: Writing 1 to bit 0 at 0x18 returns control, status and bus drive to their reset values. The register reads back 0.
- R12: Offsets 0x00, 0x04 and 0x14 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| tick | input | 1 | Quarter-bit timing pulse |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Level interrupt |

## Verification
Write transfers use random target addresses, random data bytes and a random acknowledge answer from the bench target on every byte. This separates the four write-side codes and proves the bits on the wire match the data register. Read transfers with random target bytes, with the acknowledge bit set for one byte and cleared for the last, show both that received data lands in the register and that the master's ACK/NACK choice reaches the bus. Directed cases cover the remaining steps: a repeated START followed by an unacknowledged read address, a start request with bus enable off, a flagged step with interrupt enable off, an injected SDA glitch during a byte, and a soft reset in mid-transfer. Each of these steps has its own status code or line state to compare.

// File: rtl/i2c_step_master.sv
module i2c_step_master #(
  parameter logic [7:0] IDLE_CODE = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);
  typedef enum logic [2:0] {IDLE, START, XFER, STOP, HOLD} state_t;

  state_t     st;
  logic [7:0] own_q, ext_q, dat_q, stat_q, clk_q, sh;
  logic       f_ien, f_en, f_start, f_stop, f_int, f_ack;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic       rx, rw, adr, rep, got_ack, scl_lo, sda_lo, sda_d, win_d;

  wire       srst   = reg_we && reg_addr == 5'h18 && reg_wdata[0];
  wire       win    = st == XFER && (ph == 2'd1 || ph == 2'd2) && scl_in;
  wire       berr   = win && win_d && (sda_in != sda_d);
  wire       nxt_rx = adr ? 1'b0 : rw;
  wire [7:0] ctrl   = {f_ien, f_en, f_start, f_stop, f_int, f_ack, 2'b00};
  wire [7:0] code   = rx  ? (sda_lo ? 8'h50 : 8'h58) :
                      adr ? (rw ? (got_ack ? 8'h40 : 8'h48) : (got_ack ? 8'h18 : 8'h20)) :
                            (got_ack ? 8'h28 : 8'h30);

  assign scl_oe = scl_lo;
  assign sda_oe = sda_lo;
  assign irq    = f_int & f_ien;

  always_comb begin
    case (reg_addr)
      5'h00:   reg_rdata = own_q;
      5'h04:   reg_rdata = ext_q;
      5'h08:   reg_rdata = dat_q;
      5'h0C:   reg_rdata = ctrl;
      5'h10:   reg_rdata = stat_q;
      5'h14:   reg_rdata = clk_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; own_q <= '0; ext_q <= '0; dat_q <= '0; clk_q <= '0; sh <= '0;
      stat_q <= IDLE_CODE;
      {f_ien, f_en, f_start, f_stop, f_int, f_ack} <= '0;
      ph <= '0; bitn <= '0;
      {rx, rw, adr, rep, got_ack, scl_lo, sda_lo, win_d} <= '0;
      sda_d <= 1'b1;
    end else if (srst) begin
      st <= IDLE; stat_q <= IDLE_CODE;
      {f_ien, f_en, f_start, f_stop, f_int, f_ack} <= '0;
      ph <= '0; bitn <= '0; scl_lo <= 1'b0; sda_lo <= 1'b0; win_d <= 1'b0;
    end else begin
      sda_d <= sda_in;
      win_d <= win;
      if (reg_we) begin
        case (reg_addr)
          5'h00: own_q <= reg_wdata;
          5'h04: ext_q <= reg_wdata;
          5'h08: dat_q <= reg_wdata;
          5'h14: clk_q <= reg_wdata;
          5'h0C: begin
            f_ien   <= reg_wdata[7];
            f_en    <= reg_wdata[6];
            f_start <= reg_wdata[5];
            f_stop  <= reg_wdata[4];
            f_int   <= f_int & reg_wdata[3];
            f_ack   <= reg_wdata[2];
          end
          default: ;
        endcase
      end
      if (!f_en) begin
        st <= IDLE; scl_lo <= 1'b0; sda_lo <= 1'b0;
      end else if (berr) begin
        st <= HOLD; stat_q <= 8'h00; f_int <= 1'b1; scl_lo <= 1'b0; sda_lo <= 1'b0;
      end else begin
        case (st)
          IDLE: if (f_start && !f_int) begin
            st <= START; ph <= '0; rep <= 1'b0; sda_lo <= 1'b0;
          end
          HOLD: if (!f_int) begin
            if (stat_q == 8'h00) st <= IDLE;
            else if (f_stop) begin
              st <= STOP; ph <= '0; sda_lo <= 1'b1;
            end else if (f_start) begin
              st <= START; ph <= '0; rep <= 1'b1; sda_lo <= 1'b0;
            end else begin
              st <= XFER; ph <= '0; bitn <= '0; rx <= nxt_rx; sh <= dat_q;
              sda_lo <= nxt_rx ? 1'b0 : ~dat_q[7];
              if (adr) rw <= dat_q[0];
            end
          end
          START: if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: scl_lo <= 1'b0;
              2'd1: sda_lo <= 1'b1;
              2'd2: scl_lo <= 1'b1;
              default: begin
                st <= HOLD; f_int <= 1'b1; f_start <= 1'b0; adr <= 1'b1;
                stat_q <= rep ? 8'h10 : 8'h08;
              end
            endcase
          end
          STOP: if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: scl_lo <= 1'b0;
              2'd1: sda_lo <= 1'b0;
              2'd2: ;
              default: begin st <= IDLE; f_stop <= 1'b0; end
            endcase
          end
          XFER: if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: scl_lo <= 1'b0;
              2'd1: if (bitn[3]) got_ack <= ~sda_in; else sh <= {sh[6:0], sda_in};
              2'd2: scl_lo <= 1'b1;
              default: if (bitn[3]) begin
                st <= HOLD; f_int <= 1'b1; adr <= 1'b0; stat_q <= code;
                if (rx) dat_q <= sh;
              end else begin
                bitn <= bitn + 4'd1;
                sda_lo <= (bitn == 4'd7) ? (rx & f_ack) : (~rx & ~sh[7]);
              end
            endcase
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD && f_en && stat_q != 8'h00) |-> scl_oe);

  // R10
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win && win_d) |-> $stable(sda_oe));

  // R2 R4 R5 R6 R10
  code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_int) |-> stat_q inside {8'h00, 8'h08, 8'h10, 8'h18, 8'h20, 8'h28,
                                    8'h30, 8'h40, 8'h48, 8'h50, 8'h58});

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == STOP |-> !f_int);

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !f_en |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_step_master_test.sv
module i2c_step_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  wire  [7:0] reg_rdata;
  logic       tick = 1'b0;
  wire        scl_oe, sda_oe, irq;
  logic       drv = 1'b0, glitch = 1'b0;
  wire        scl_w = ~scl_oe;
  wire        sda_w = ~sda_oe & ~drv & ~glitch;

  i2c_step_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .scl_in(scl_w), .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [7:0] IEN = 8'h80, EN = 8'h40, STA = 8'h20, STO = 8'h10, AAK = 8'h04;

  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  // bench target on the bus
  logic       scl_p = 1'b1, sda_p = 1'b1, mack = 1'b0, ack_en = 1'b1;
  int         bitc = 0, phase = 0, starts = 0, stops = 0, nbytes = 0, txi = 0;
  logic [7:0] inb = '0, txsh = '0, last_byte = '0;
  logic [7:0] txq [4];

  always @(negedge clk) begin
    logic load;
    load = 1'b0;
    if (scl_w && scl_p && sda_p && !sda_w) begin
      starts++; phase = 1; bitc = 0; drv = 1'b0;
    end else if (scl_w && scl_p && !sda_p && sda_w) begin
      stops++; phase = 0; drv = 1'b0;
    end else if (phase != 0 && scl_w && !scl_p) begin
      if (bitc < 8) inb = {inb[6:0], sda_w}; else mack = !sda_w;
      bitc++;
    end else if (phase != 0 && !scl_w && scl_p) begin
      if (bitc == 8) begin
        if (phase == 3) drv = 1'b0;
        else begin drv = ack_en; last_byte = inb; nbytes++; end
      end else if (bitc == 9) begin
        bitc = 0; drv = 1'b0;
        if (phase == 1) begin
          if (!ack_en) phase = 0;
          else if (inb[0]) begin phase = 3; load = 1'b1; end
          else phase = 2;
        end else if (phase == 3) begin
          if (mack) load = 1'b1; else phase = 0;
        end
      end else if (phase == 3) begin
        drv = !txsh[7]; txsh = txsh << 1;
      end
      if (load) begin
        txsh = txq[txi % 4]; txi++;
        drv = !txsh[7]; txsh = txsh << 1;
      end
    end
    scl_p = scl_w; sda_p = sda_w;
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wait_flag(input string r);
    logic [7:0] v;
    v = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(5'h0C, v);
      if (v[3]) break;
    end
    chk({r, " flag raised"}, int'(v[3]), 1);
  endtask

  function automatic logic [7:0] exp_tx(input bit is_adr, input bit rdb, input bit ack);
    if (is_adr) return rdb ? (ack ? 8'h40 : 8'h48) : (ack ? 8'h18 : 8'h20);
    return ack ? 8'h28 : 8'h30;
  endfunction

  task automatic do_start(input logic [7:0] base, input logic [7:0] exp, input string r);
    logic [7:0] v;
    wr(5'h0C, base | STA);
    wait_flag(r);
    rd(5'h10, v); chk({r, " start code"}, v, exp);
    rd(5'h0C, v); chk({r, " start bit cleared"}, int'(v[5]), 0);
  endtask

  task automatic send(input logic [7:0] base, input logic [7:0] b, input logic [7:0] exp, input string r);
    logic [7:0] v;
    wr(5'h08, b);
    wr(5'h0C, base);
    wait_flag(r);
    rd(5'h10, v); chk({r, " byte code"}, v, exp);
  endtask

  task automatic do_stop(input logic [7:0] base);
    logic [7:0] v;
    int s0;
    s0 = stops;
    wr(5'h0C, base | STO);
    repeat (60) @(negedge clk);
    chk("R7 stop seen on bus", stops - s0, 1);
    rd(5'h0C, v); chk("R7 control after stop", v, base);
    chk("R7 lines released", {scl_oe, sda_oe}, 0);
    chk("R7 no interrupt", irq, 0);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    rd(5'h10, v); chk("R1 status", v, 8'hF8);
    rd(5'h0C, v); chk("R1 control", v, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);
    chk("R1 irq", irq, 0);

    // R12
    wr(5'h00, 8'h5A); wr(5'h04, 8'hA5); wr(5'h14, 8'h3C);
    rd(5'h00, v); chk("R12 own addr", v, 8'h5A);
    rd(5'h04, v); chk("R12 ext addr", v, 8'hA5);
    rd(5'h14, v); chk("R12 clock reg", v, 8'h3C);

    // R9
    wr(5'h0C, IEN | STA);
    repeat (60) @(negedge clk);
    chk("R9 no start on bus", starts, 0);
    chk("R9 lines released", {scl_oe, sda_oe}, 0);
    rd(5'h10, v); chk("R9 status unchanged", v, 8'hF8);
    wr(5'h0C, 8'h00);

    // random write transfers: R2 R3 R4 R5 R8
    for (int t = 0; t < 6; t++) begin
      logic [6:0] a;
      int nb, s0;
      a = 7'($urandom());
      nb = 1 + ($urandom() % 2);
      ack_en = ($urandom() % 4) != 0;
      s0 = starts;
      do_start(IEN | EN, 8'h08, "R2");
      chk("R2 start on bus", starts - s0, 1);
      chk("R8 irq with enable", irq, 1);
      repeat (20) @(negedge clk);
      chk("R3 scl held while frozen", scl_oe, 1);
      send(IEN | EN, {a, 1'b0}, exp_tx(1, 0, ack_en), "R4");
      chk("R4 address on bus", last_byte, {a, 1'b0});
      if (ack_en) begin
        for (int k = 0; k < nb; k++) begin
          logic [7:0] d;
          d = 8'($urandom());
          ack_en = ($urandom() % 3) != 0;
          send(IEN | EN, d, exp_tx(0, 0, ack_en), "R5");
          chk("R5 data on bus", last_byte, d);
        end
      end
      do_stop(IEN | EN);
      ack_en = 1'b1;
    end

    // R6 read transfer
    begin
      logic [6:0] a;
      a = 7'($urandom());
      txq[0] = 8'($urandom()); txq[1] = 8'($urandom()); txi = 0;
      ack_en = 1'b1;
      do_start(IEN | EN, 8'h08, "R2");
      send(IEN | EN, {a, 1'b1}, 8'h40, "R4 read addr");
      wr(5'h0C, IEN | EN | AAK);
      wait_flag("R6");
      rd(5'h10, v); chk("R6 acked byte code", v, 8'h50);
      rd(5'h08, v); chk("R6 first byte", v, txq[0]);
      chk("R6 master ack on bus", mack, 1);
      wr(5'h0C, IEN | EN);
      wait_flag("R6");
      rd(5'h10, v); chk("R6 nacked byte code", v, 8'h58);
      rd(5'h08, v); chk("R6 last byte", v, txq[1]);
      chk("R6 master nack on bus", mack, 0);
      do_stop(IEN | EN);
    end

    // R2 repeated start, R4 unacked read address
    begin
      int s0;
      do_start(IEN | EN, 8'h08, "R2");
      send(IEN | EN, 8'hA4, 8'h18, "R4");
      s0 = starts;
      do_start(IEN | EN, 8'h10, "R2 repeated");
      chk("R2 repeated start on bus", starts - s0, 1);
      ack_en = 1'b0;
      send(IEN | EN, 8'hA5, 8'h48, "R4 read nack");
      do_stop(IEN | EN);
      ack_en = 1'b1;
    end

    // R8 interrupt enable gating, R3 flag write of 1
    wr(5'h0C, EN | STA);
    wait_flag("R8");
    chk("R8 irq masked", irq, 0);
    wr(5'h0C, IEN | EN | 8'h08);
    @(negedge clk);
    chk("R8 irq after enable", irq, 1);
    rd(5'h0C, v); chk("R3 flag kept", int'(v[3]), 1);
    wr(5'h0C, IEN | EN | STO);
    repeat (60) @(negedge clk);
    rd(5'h0C, v); chk("R7 control after stop", v, IEN | EN);

    // R10 bus error
    do_start(IEN | EN, 8'h08, "R2");
    send(IEN | EN, 8'h22, 8'h18, "R4");
    wr(5'h08, 8'hFF);
    wr(5'h0C, IEN | EN);
    for (int i = 0; i < 500 && !scl_w; i++) @(negedge clk);
    @(negedge clk);
    glitch = 1'b1;
    wait_flag("R10");
    glitch = 1'b0;
    rd(5'h10, v); chk("R10 error code", v, 8'h00);
    chk("R10 lines released", {scl_oe, sda_oe}, 0);
    wr(5'h0C, IEN | EN);
    repeat (10) @(negedge clk);
    chk("R10 idle after clear", {scl_oe, sda_oe}, 0);
    do_start(IEN | EN, 8'h08, "R10 restart");
    do_stop(IEN | EN);

    // R11 soft reset
    do_start(IEN | EN, 8'h08, "R2");
    wr(5'h18, 8'h01);
    rd(5'h0C, v); chk("R11 control", v, 0);
    rd(5'h10, v); chk("R11 status", v, 8'hF8);
    rd(5'h18, v); chk("R11 reads zero", v, 0);
    chk("R11 lines", {scl_oe, sda_oe}, 0);
    chk("R11 irq", irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule